// File: doc/BRIEF.md
# Seven-to-one serial lane deserializer

This receiver rebuilds wide parallel words from a source-synchronous link made of several serial data lanes and one forwarded clock lane. All lanes are sampled by an external sampling clock that runs at seven times the frame rate, one sample per bit slot. A frame is found by watching the last seven clock-lane samples for the fixed clock shape. Each data lane then contributes seven bits to the output word.

The word is presented with a frame-rate strobe. The word register loads in the same cycle that the strobe falls, and the strobe rises half a frame later, so downstream logic can capture on the strobe's rising edge. Output updates start only after a run of correctly spaced frames. They stop when the clock-lane shape disappears or when the active-low power-down input is low. In both cases the outputs keep their last values rather than clearing.

Top module: `lvds7_deser`

## Requirements
- R1: Within a frame, data lane L carries slots 0 to 6 in time order (slot 0 is received first), and slot k of lane L appears on `word_out` bit 7*L+k.
- R2: A frame is complete when the last seven clock-lane samples, oldest first, read 1,1,0,0,0,1,1. Those seven samples are slots 0 to 6 of that frame.
- R3: `word_out` changes only on the clock edge where `strobe_out` falls. `strobe_out` stays low for exactly 4 sampling cycles and then rises, so the word is steady at every rising edge of the strobe.
- R4: `locked_out` rises on the cycle after the LOCK_FRAMES-th consecutive frame match, where consecutive means exactly 7 sampling cycles apart. That frame is the first word presented, and no earlier frame reaches `word_out`.
- R5: While `pwr_n` is low, `word_out` and `strobe_out` hold their values and `locked_out` is low. After `pwr_n` returns high, the lock interval of R4 starts again.
- R6: If no frame match occurs 7 sampling cycles after the previous match, `locked_out` falls. `word_out` then keeps the last presented word, and `strobe_out` makes no edge until the link has locked again.
- R7: During reset, `word_out` is 0, `strobe_out` is 1 and `locked_out` is 0.
- R8: While the link is locked, every matched frame is presented exactly once, in the order it was received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Sampling clock at seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; low holds all outputs |
| clk_lane_in | input | 1 | Sampled forwarded clock lane |
| data_lanes_in | input | LANES | Sampled serial data lanes |
| word_out | output | 7*LANES | Rebuilt parallel word |
| strobe_out | output | 1 | Frame-rate strobe; the rising edge marks a valid word |
| locked_out | output | 1 | Frame alignment is established |

## Verification
The bench uses four lanes and LOCK_FRAMES set to 3. With these values a relock after clock loss, a relock after power-down, and a skipped early frame each take only a few frames. As a result, every lock interval in the run reaches its boundary: the third frame is the first one presented. The scoreboard predicts which frames must appear from its own count of consecutive frames. It also checks that the strobe makes no edges and the word stays put across a stopped clock lane and across a power-down in which full valid frames keep arriving.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  localparam int unsigned SLOTS = 7;
  localparam logic [SLOTS-1:0] FRAME_MARK = 7'b1100011;
  localparam int unsigned PHASE_W = 3;
  localparam logic [PHASE_W-1:0] PHASE_LAST = 3'd6;
  localparam logic [PHASE_W-1:0] PHASE_RISE = 3'd3;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/lvds7_shift.sv
module lvds7_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (en) q_n = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/lvds7_lock.sv
module lvds7_lock
  import lvds7_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [SLOTS-1:0] mark_i,
  output logic             update_o,
  output phase_t           phase_o,
  output logic             locked_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_FRAMES);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(LOCK_FRAMES - 1);

  phase_t           phase_q, phase_n;
  logic [RUN_W-1:0] run_q, run_n;
  logic             match, spaced;

  always_comb begin
    match  = (mark_i == FRAME_MARK);
    spaced = match && (phase_q == PHASE_LAST);
    // phase counts sampling cycles since the last match, saturating
    if (match)                        phase_n = '0;
    else if (phase_q == PHASE_LAST)   phase_n = phase_q;
    else                              phase_n = phase_q + 1'b1;
    run_n = run_q;
    if (!pwr_n)                       run_n = '0;
    else if (spaced)                  run_n = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else if (match)                   run_n = RUN_W'(1);
    else if (phase_q == PHASE_LAST)   run_n = '0;
    update_o = pwr_n && spaced && (run_q >= RUN_PRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PHASE_LAST;
      run_q   <= '0;
    end else begin
      phase_q <= phase_n;
      run_q   <= run_n;
    end
  end

  assign phase_o  = phase_q;
  assign locked_o = (run_q == RUN_MAX);
endmodule

// File: rtl/lvds7_present.sv
module lvds7_present
  import lvds7_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_n,
  input  logic                   update_i,
  input  phase_t                 phase_i,
  input  logic [LANES*SLOTS-1:0] lanes_i,
  output logic [LANES*SLOTS-1:0] word_o,
  output logic                   strobe_o
);
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic [WORD_W-1:0] unpacked;
  logic [WORD_W-1:0] word_n;
  logic              strobe_n;

  // shift registers hold slot 0 at the top bit of each lane field
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign unpacked[l*SLOTS + k] = lanes_i[l*SLOTS + (SLOTS-1-k)];
    end
  end

  always_comb begin
    word_n   = word_o;
    strobe_n = strobe_o;
    if (update_i) begin
      word_n   = unpacked;
      strobe_n = 1'b0;
    end else if (pwr_n && (phase_i == PHASE_RISE)) begin
      strobe_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o   <= '0;
      strobe_o <= 1'b1;
    end else begin
      word_o   <= word_n;
      strobe_o <= strobe_n;
    end
  end
endmodule

// File: rtl/lvds7_deser.sv
module lvds7_deser
  import lvds7_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned LOCK_FRAMES = 16
) (
  input  logic                   clk_fast,
  input  logic                   rst_n,
  input  logic                   pwr_n,
  input  logic                   clk_lane_in,
  input  logic [LANES-1:0]       data_lanes_in,
  output logic [LANES*SLOTS-1:0] word_out,
  output logic                   strobe_out,
  output logic                   locked_out
);
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [SLOTS-1:0]  mark;
  logic [WORD_W-1:0] lanes_flat;
  logic              update;
  phase_t            phase;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lvds7_shift #(.W(SLOTS)) i_mark_sr (
    .clk(clk_fast), .rst_n(rst_int_n), .en(1'b1),
    .din(clk_lane_in), .q(mark)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_data_sr
    lvds7_shift #(.W(SLOTS)) i_sr (
      .clk(clk_fast), .rst_n(rst_int_n), .en(1'b1),
      .din(data_lanes_in[l]), .q(lanes_flat[l*SLOTS +: SLOTS])
    );
  end

  lvds7_lock #(.LOCK_FRAMES(LOCK_FRAMES)) i_lock (
    .clk(clk_fast), .rst_n(rst_int_n), .pwr_n(pwr_n), .mark_i(mark),
    .update_o(update), .phase_o(phase), .locked_o(locked_out)
  );

  lvds7_present #(.LANES(LANES)) i_present (
    .clk(clk_fast), .rst_n(rst_int_n), .pwr_n(pwr_n), .update_i(update),
    .phase_i(phase), .lanes_i(lanes_flat),
    .word_o(word_out), .strobe_o(strobe_out)
  );
endmodule

// File: rtl/lvds7_deser_chk.sv
module lvds7_deser_chk #(
  parameter int unsigned WORD_W = 28
) (
  input logic              clk_fast,
  input logic              rst_n,
  input logic              pwr_n,
  input logic [WORD_W-1:0] word_out,
  input logic              strobe_out,
  input logic              locked_out
);
  assert_word_moves_on_strobe_fall_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(word_out) |-> $fell(strobe_out));

  assert_strobe_low_four_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($fell(strobe_out) && pwr_n) |=> !strobe_out);

  assert_update_needs_lock_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(word_out) |-> locked_out);

  assert_hold_in_powerdown_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !pwr_n |=> ($stable(word_out) && $stable(strobe_out)));

  assert_powerdown_drops_lock_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !pwr_n |=> !locked_out);
endmodule

bind lvds7_deser lvds7_deser_chk #(.WORD_W(LANES*7)) i_lvds7_deser_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .pwr_n(pwr_n),
  .word_out(word_out), .strobe_out(strobe_out), .locked_out(locked_out)
);

// File: tb/test_lvds7_deser.sv
module test_lvds7_deser;
  localparam int LANES  = 4;
  localparam int LOCK   = 3;
  localparam int WORD_W = LANES * 7;
  localparam logic [6:0] MARK = 7'b1100011;

  logic              clk_fast = 1'b0;
  logic              rst_n, pwr_n, clk_lane_in;
  logic [LANES-1:0]  data_lanes_in;
  logic [WORD_W-1:0] word_out;
  logic              strobe_out, locked_out;

  int checks = 0, failures = 0, rises = 0, run_m = 0, pushed = 0;
  logic [WORD_W-1:0] expq[$];
  logic [WORD_W-1:0] last_pushed = '0;
  logic              strobe_prev = 1'b1;
  logic [WORD_W-1:0] word_prev = '0;

  always #5 clk_fast = ~clk_fast;

  lvds7_deser #(.LANES(LANES), .LOCK_FRAMES(LOCK)) i_lvds7_deser (
    .clk_fast(clk_fast), .rst_n(rst_n), .pwr_n(pwr_n), .clk_lane_in(clk_lane_in),
    .data_lanes_in(data_lanes_in), .word_out(word_out),
    .strobe_out(strobe_out), .locked_out(locked_out)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [WORD_W-1:0] w);
    if (pwr_n) begin
      run_m++;
      if (run_m >= LOCK) begin
        expq.push_back(w);
        last_pushed = w;
        pushed++;
      end
    end
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_fast);
      clk_lane_in = MARK[6-k];
      for (int l = 0; l < LANES; l++) data_lanes_in[l] = w[7*l + k];
    end
  endtask

  task automatic idle(input int n, input logic lvl);
    run_m = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_fast);
      clk_lane_in   = lvl;
      data_lanes_in = LANES'($urandom);
    end
  endtask

  // monitor: scoreboard pop on every rising strobe, steady word while strobe high
  always @(negedge clk_fast) begin
    if (rst_n) begin
      if (strobe_out && !strobe_prev) begin
        rises++;
        if (expq.size() == 0) check(1'b0, "R8 unexpected word", 64'(word_out), 64'(0));
        else begin
          logic [WORD_W-1:0] e;
          e = expq.pop_front();
          check(word_out == e, "R1 word at strobe rise", 64'(word_out), 64'(e));
        end
      end
      if (strobe_out && strobe_prev && word_out != word_prev)
        check(1'b0, "R3 word moved while strobe high", 64'(word_out), 64'(word_prev));
    end
    strobe_prev = strobe_out;
    word_prev   = word_out;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; pwr_n = 1'b1; clk_lane_in = 1'b0; data_lanes_in = '0;
    repeat (5) @(negedge clk_fast);
    check(word_out == '0, "R7 word reset", 64'(word_out), 64'(0));
    check(strobe_out == 1'b1, "R7 strobe reset", 64'(strobe_out), 64'(1));
    check(locked_out == 1'b0, "R7 lock reset", 64'(locked_out), 64'(0));
    rst_n = 1'b1;
    idle(10, 1'b0);

    // R4: first LOCK-1 frames are not presented
    send_frame(28'h0AAAAAA);
    send_frame(28'h5555555);
    send_frame(28'h0000001);
    check(locked_out == 1'b0, "R4 not locked after two frames", 64'(locked_out), 64'(0));
    send_frame(28'hFFFFFFF);
    check(locked_out == 1'b1, "R4 locked after third frame", 64'(locked_out), 64'(1));
    // R1 R2 R8 walking one and random patterns
    for (int i = 0; i < WORD_W; i += 3) send_frame(WORD_W'(1) << i);
    for (int i = 0; i < 8; i++) send_frame(WORD_W'($urandom));

    // R6: clock lane stops high
    idle(12, 1'b1);
    snap = rises;
    idle(30, 1'b1);
    check(rises == snap, "R6 no strobe edge after clock stop", 64'(rises), 64'(snap));
    check(word_out == last_pushed, "R6 word held", 64'(word_out), 64'(last_pushed));
    check(locked_out == 1'b0, "R6 lock dropped", 64'(locked_out), 64'(0));
    check(strobe_out == 1'b1, "R6 strobe steady", 64'(strobe_out), 64'(1));
    for (int i = 0; i < 6; i++) send_frame(WORD_W'($urandom));

    // R5: power-down with valid frames arriving
    idle(12, 1'b0);
    pwr_n = 1'b0;
    idle(3, 1'b0);
    snap = rises;
    for (int i = 0; i < 5; i++) send_frame(WORD_W'($urandom));
    idle(5, 1'b0);
    check(rises == snap, "R5 no strobe edge in power-down", 64'(rises), 64'(snap));
    check(word_out == last_pushed, "R5 word held", 64'(word_out), 64'(last_pushed));
    check(locked_out == 1'b0, "R5 lock low", 64'(locked_out), 64'(0));
    pwr_n = 1'b1;
    idle(5, 1'b0);
    for (int i = 0; i < 6; i++) send_frame(WORD_W'($urandom));
    idle(20, 1'b0);

    check(expq.size() == 0, "R8 all expected words presented", 64'(expq.size()), 64'(0));
    check(rises == pushed, "R8 one strobe per frame", 64'(rises), 64'(pushed));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule